// File: doc/BRIEF.md
# Double-Buffered Aligned PWM Channel

This block generates one pulse-width modulated waveform from an 8-bit counter. The counter advances once per clock-enable tick while the channel is enabled. In edge mode it counts upward and wraps. In symmetric mode it counts up to the period value and then back down to zero, so the pulse sits centred in each cycle.

Software writes the period and duty values into staging registers. The counter and the output compare logic never read those staging registers directly. They use a separate working copy, which is refreshed only at safe points: when a cycle completes, when the counter is written, and on every clock while the channel is disabled. A period or duty change therefore never produces a truncated or malformed pulse. A write of any value to the counter restarts the cycle at once. The current count is always visible on its own output port.

Top module: `pwm_aligned_chan`

## Requirements
- R1: After reset the count is 0 and the output sits at the full-duty level, equal to `polarity`, because the working period and duty are both 0.
- R2: A period or duty write while the channel runs changes only the staging copy; the running cycle keeps its old period and duty until a load point.
- R3: With `centerMode` = 0 and working period P > 0, the count steps 0, 1, …, P-1 on successive ticks and then returns to 0.
- R4: With `centerMode` = 1 and working period P > 0, the count steps up from 0 to P and then down to 0, so one cycle spans 2·P ticks.
- R5: The count changes only on clock edges where `tick` is 1.
- R6: While `chanEn` is 0 the count holds, and the staging values are copied into the working registers on every clock.
- R7: Asserting `wrCount` clears the count to 0, sets the direction to up, and loads the working period and duty from staging at the same edge. Because the count is then 0, the output shows the `polarity` level whenever the new duty is nonzero.
- R8: The output is active while count < working duty and inactive otherwise. The active level is 1 when `polarity` = 1 and 0 when `polarity` = 0. In symmetric mode this makes the output change at the duty match on both the rising and the falling slope.
- R9: Duty 0 gives a constant inactive output. Duty ≥ period gives a constant active output. Period 0 holds the count at 0 with the output active.
- R10: At the end of every cycle the count returns to 0 and the staging values are copied into the working registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Clock-enable tick from the selected clock source |
| chanEn | input | 1 | Channel enable |
| polarity | input | 1 | 1: output active-high; 0: output active-low |
| centerMode | input | 1 | 0: edge (up-count) mode; 1: symmetric up/down mode |
| wrPeriod | input | 1 | Write strobe for the period staging register |
| wrDuty | input | 1 | Write strobe for the duty staging register |
| wrCount | input | 1 | Counter write strobe; restarts the cycle |
| wrData | input | 8 | Write data for the period and duty strobes |
| countOut | output | 8 | Current count, readable at any time |
| pwmOut | output | 1 | PWM waveform |

## Verification
A wrong direction bit or a wrong count shows on `countOut` at the first tick after the fault. It also shifts the `pwmOut` edges within the same cycle, because the output compare reads the count directly. A working register loaded at the wrong moment shows only at the next wrap or turn point, which can be up to 2·P ticks later. The checks therefore sample the count right after a period boundary as well as in the middle of a cycle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef struct packed {
    logic inc;   // step count up
    logic dec;   // step count down
    logic clr;   // return count to zero
    logic load;  // copy staging into working registers
  } ctrlStrobe_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             chanEn,
  input  logic             centerMode,
  input  logic             wrCount,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] perAct,
  output ctrlStrobe_t      strobe
);
  localparam int EXT_W = CNT_W + 1;

  logic dirUp;
  logic dirNext;
  logic [EXT_W-1:0] countPlus;
  logic perZero;

  assign countPlus = {1'b0, count} + EXT_W'(1);
  assign perZero   = (perAct == '0);

  always_comb begin
    strobe  = '0;
    dirNext = dirUp;
    if (wrCount) begin
      strobe.clr  = 1'b1;
      strobe.load = 1'b1;
      dirNext     = 1'b1;
    end else if (!chanEn) begin
      strobe.load = 1'b1;
    end else if (tick) begin
      if (perZero) begin
        strobe.clr  = 1'b1;
        strobe.load = 1'b1;
        dirNext     = 1'b1;
      end else if (!centerMode) begin
        if (countPlus >= {1'b0, perAct}) begin
          strobe.clr  = 1'b1;
          strobe.load = 1'b1;
          dirNext     = 1'b1;
        end else begin
          strobe.inc = 1'b1;
        end
      end else if (dirUp) begin
        strobe.inc = 1'b1;
        if (countPlus >= {1'b0, perAct}) dirNext = 1'b0;
      end else begin
        if (count <= CNT_W'(1)) begin
          strobe.clr  = 1'b1;
          strobe.load = 1'b1;
          dirNext     = 1'b1;
        end else begin
          strobe.dec = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dirUp <= 1'b1;
    else       dirUp <= dirNext;
  end

  // R6: disabled channel keeps its count
  p_hold_disabled_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!chanEn && !wrCount) |=> $stable(count));

  // R5: no tick, no movement
  p_tick_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !wrCount) |=> $stable(count));

  // R7: counter write restarts counting upward from zero
  p_cntwr_reset_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrCount |=> (count == '0) && dirUp);

  // R4: direction turns only at the top of the period
  p_turn_top_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dirUp) |-> (count == perAct));

  // R3: edge mode never reaches the period value
  p_left_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!centerMode && chanEn && !wrCount && perAct != '0 && count < perAct)
      |=> (count < $past(perAct)) || (count == '0));
endmodule

// File: rtl/pwm_dp.sv
module pwm_dp
  import pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic             wrPeriod,
  input  logic             wrDuty,
  input  logic [CNT_W-1:0] wrData,
  input  logic             polarity,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] perAct,
  output logic             pwmOut
);
  logic [CNT_W-1:0] perBuf;
  logic [CNT_W-1:0] dutyBuf;
  logic [CNT_W-1:0] dutyAct;
  logic             active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perBuf  <= '0;
      dutyBuf <= '0;
    end else begin
      if (wrPeriod) perBuf  <= wrData;
      if (wrDuty)   dutyBuf <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perAct  <= '0;
      dutyAct <= '0;
    end else if (strobe.load) begin
      perAct  <= perBuf;
      dutyAct <= dutyBuf;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           count <= '0;
    else if (strobe.clr) count <= '0;
    else if (strobe.inc) count <= count + CNT_W'(1);
    else if (strobe.dec) count <= count - CNT_W'(1);
  end

  assign active = (dutyAct >= perAct) || (count < dutyAct);
  assign pwmOut = polarity ? active : ~active;

  // R2: working values stay put between load points
  p_hold_active_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(perAct) && $stable(dutyAct));

  // R9: a zero period never lets the count leave zero
  p_zero_period_r9: assert property (@(posedge clk) disable iff (!rstN)
    (perAct == '0 && count == '0 && !strobe.load) |=> (count == '0));
endmodule

// File: rtl/pwm_aligned_chan.sv
module pwm_aligned_chan
  import pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             chanEn,
  input  logic             polarity,
  input  logic             centerMode,
  input  logic             wrPeriod,
  input  logic             wrDuty,
  input  logic             wrCount,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countOut,
  output logic             pwmOut
);
  ctrlStrobe_t      strobe;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] perAct;

  pwm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .chanEn(chanEn),
    .centerMode(centerMode), .wrCount(wrCount), .count(count),
    .perAct(perAct), .strobe(strobe)
  );

  pwm_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrPeriod(wrPeriod),
    .wrDuty(wrDuty), .wrData(wrData), .polarity(polarity),
    .count(count), .perAct(perAct), .pwmOut(pwmOut)
  );

  assign countOut = count;
endmodule

// File: tb/sim_pwm_aligned_chan.sv
module sim_pwm_aligned_chan;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, chanEn = 1'b0, polarity = 1'b1, centerMode = 1'b0;
  logic wrPeriod = 1'b0, wrDuty = 1'b0, wrCount = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] countOut;
  logic pwmOut;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_aligned_chan u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .chanEn(chanEn),
    .polarity(polarity), .centerMode(centerMode), .wrPeriod(wrPeriod),
    .wrDuty(wrDuty), .wrCount(wrCount), .wrData(wrData),
    .countOut(countOut), .pwmOut(pwmOut)
  );

  typedef struct packed {
    logic       pol;
    logic       ctr;
    logic [7:0] per;
    logic [7:0] duty;
    logic [7:0] steps;
    logic [7:0] expCnt;
    logic       expOut;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 8'd5, 8'd2, 8'd3, 8'd3, 1'b0},  // R3 R8 mid cycle
    '{1'b1, 1'b0, 8'd5, 8'd2, 8'd5, 8'd0, 1'b1},  // R3 R10 wrap
    '{1'b0, 1'b0, 8'd5, 8'd2, 8'd1, 8'd1, 1'b0},  // R8 inverted
    '{1'b1, 1'b1, 8'd4, 8'd1, 8'd4, 8'd4, 1'b0},  // R4 top
    '{1'b1, 1'b1, 8'd4, 8'd1, 8'd7, 8'd1, 1'b0},  // R4 down slope
    '{1'b1, 1'b1, 8'd4, 8'd1, 8'd8, 8'd0, 1'b1},  // R4 R10 end 2P
    '{1'b0, 1'b1, 8'd3, 8'd2, 8'd5, 8'd1, 1'b0},  // R8 down slope inverted
    '{1'b1, 1'b0, 8'd5, 8'd0, 8'd2, 8'd2, 1'b0},  // R9 duty zero
    '{1'b1, 1'b0, 8'd5, 8'd7, 8'd4, 8'd4, 1'b1},  // R9 duty over period
    '{1'b1, 1'b0, 8'd0, 8'd3, 8'd3, 8'd0, 1'b1}   // R9 period zero
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic pol, input logic ctr, input logic [7:0] per, input logic [7:0] duty);
    chanEn = 1'b0; polarity = pol; centerMode = ctr;
    wrPeriod = 1'b1; wrData = per;
    edges(1);
    wrPeriod = 1'b0; wrDuty = 1'b1; wrData = duty;
    edges(1);
    wrDuty = 1'b0; wrCount = 1'b1;
    edges(1);
    wrCount = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    edges(2);
    // R1 reset state
    chk("R1 count", countOut, 8'd0);
    chk("R1 out", {7'd0, pwmOut}, 8'd1);
    rstN = 1'b1;
    edges(1);

    for (int i = 0; i < NV; i++) begin
      setup(VEC[i].pol, VEC[i].ctr, VEC[i].per, VEC[i].duty);
      chanEn = 1'b1; tick = 1'b1;
      edges(VEC[i].steps);
      chanEn = 1'b0;
      chk($sformatf("R3/R4 vec%0d count", i), countOut, VEC[i].expCnt);
      chk($sformatf("R8/R9 vec%0d out", i), {7'd0, pwmOut}, {7'd0, VEC[i].expOut});
    end

    // R5: no tick, no movement
    setup(1'b1, 1'b0, 8'd6, 8'd3);
    chanEn = 1'b1; tick = 1'b1;
    edges(2);
    tick = 1'b0;
    edges(3);
    chk("R5 count without tick", countOut, 8'd2);
    // R6: disabled holds
    chanEn = 1'b0; tick = 1'b1;
    edges(3);
    chk("R6 count while disabled", countOut, 8'd2);

    // R2 / R10: staged period waits for the wrap
    setup(1'b1, 1'b0, 8'd4, 8'd2);
    chanEn = 1'b1; tick = 1'b1;
    edges(2);
    wrPeriod = 1'b1; wrData = 8'd8;
    edges(1);
    wrPeriod = 1'b0;
    edges(1);
    chk("R2 old period kept", countOut, 8'd0);
    edges(5);
    chk("R10 new period after wrap", countOut, 8'd5);

    // R7: counter write loads staged duty at once
    wrDuty = 1'b1; wrData = 8'd6;
    edges(1);
    wrDuty = 1'b0; wrCount = 1'b1;
    edges(1);
    wrCount = 1'b0;
    chk("R7 count cleared", countOut, 8'd0);
    chk("R7 out at polarity", {7'd0, pwmOut}, 8'd1);
    edges(1);
    chk("R7 new duty active", {7'd0, pwmOut}, 8'd1);
    chk("R7 count resumes", countOut, 8'd1);

    // R7: direction forced up in symmetric mode
    setup(1'b1, 1'b1, 8'd4, 8'd2);
    chanEn = 1'b1; tick = 1'b1;
    edges(5);
    chk("R4 descending", countOut, 8'd3);
    wrCount = 1'b1;
    edges(1);
    wrCount = 1'b0;
    edges(1);
    chk("R7 direction up", countOut, 8'd1);
    chanEn = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule